// File: doc/BRIEF.md
# Microprogram Sequencer with Two Opcode Dispatch Tables

This block is the control unit of a multi-cycle processor, built as a microcoded sequencer. A 4-bit microprogram counter selects one word from a constant control store inside the block. Each word supplies 16 bits of datapath control and a 2-bit sequencing field. Address-select logic reads the sequencing field and picks the next micro-address from one of four sources. The sources are a restart at address 0, the current address plus one, and two dispatch tables that are indexed by the 6-bit opcode.

The microprogram has ten named states, each at a fixed address. FETCH (0) is followed by DECODE (1), which does the first dispatch. MEM_ADDR (2) does the second dispatch, to MEM_READ (3) or MEM_WRITE (5). MEM_READ steps on to LOAD_WB (4), and EXECUTE (6) steps on to ALU_WB (7). BRANCH (8) and JUMP (9) are also in the store. LOAD_WB, MEM_WRITE, ALU_WB, BRANCH and JUMP each return to FETCH. The datapath samples the control outputs in the same cycle the micro-address is shown on `uaddr`.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `uaddr` becomes 0 (FETCH). The control outputs then carry the FETCH word.
- R2: Sequencing code 2'b11 (increment) belongs to FETCH, MEM_READ and EXECUTE. These states step to the next address (1, 4 and 7) whatever the opcode is.
- R3: Sequencing code 2'b00 (restart) belongs to LOAD_WB, MEM_WRITE, ALU_WB, BRANCH and JUMP. These states go to address 0 whatever the opcode is.
- R4: DECODE uses code 2'b01 (first dispatch table). It goes to EXECUTE for opcode 6'h00, to MEM_ADDR for 6'h23 or 6'h2B, to BRANCH for 6'h04 and to JUMP for 6'h02.
- R5: MEM_ADDR uses code 2'b10 (second dispatch table). It goes to MEM_READ for opcode 6'h23 and to MEM_WRITE for 6'h2B.
- R6: An opcode that is not listed in the table being used sends the sequencer to address 0. This holds in both DECODE and MEM_ADDR.
- R7: The control outputs match the state. FETCH: mem_read, ir_load, pc_load, alu_b_sel=01. DECODE: alu_b_sel=11. MEM_ADDR: alu_a_sel, alu_b_sel=10. MEM_READ: mem_read, addr_sel_data. LOAD_WB: rf_write, wb_sel_mem. MEM_WRITE: mem_write, addr_sel_data. EXECUTE: alu_a_sel, alu_mode=10. ALU_WB: rf_write, rf_dst_sel. BRANCH: alu_a_sel, alu_mode=01, pc_load_if_zero, pc_next_sel=01. JUMP: pc_load, pc_next_sel=10. Every output not listed for a state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_load | output | 1 | Load the program counter unconditionally |
| pc_load_if_zero | output | 1 | Load the program counter when the ALU result is zero |
| addr_sel_data | output | 1 | Memory address comes from the ALU output register, not the PC |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_load | output | 1 | Load the instruction register |
| wb_sel_mem | output | 1 | Register write data comes from memory data |
| pc_next_sel | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 from function field |
| alu_b_sel | output | 2 | ALU B operand: 00 register, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register |
| rf_write | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field select |
| uaddr | output | 4 | Current micro-address |

## Verification
If the microprogram counter goes wrong, `uaddr` shows it in the very next cycle. The control outputs change with it, because they are fixed by the address, so a wrong store word shows up at once as a control mismatch. A wrong dispatch entry or a wrong sequencing code lands the counter in an unexpected state one edge after DECODE or MEM_ADDR. It then also changes the rest of the instruction's state path, so the error keeps showing until the next return to FETCH.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W   = 6;
    localparam int UADDR_W = 4;
    localparam int CTRL_W  = 16;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;

    typedef enum logic [UADDR_W-1:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_MEM_READ  = 4'd3,
        ST_LOAD_WB   = 4'd4,
        ST_MEM_WRITE = 4'd5,
        ST_EXECUTE   = 4'd6,
        ST_ALU_WB    = 4'd7,
        ST_BRANCH    = 4'd8,
        ST_JUMP      = 4'd9
    } ustate_t;

    typedef enum logic [1:0] {
        SEQ_FETCH = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_t;

    typedef struct packed {
        logic       pc_load;
        logic       pc_load_if_zero;
        logic       addr_sel_data;
        logic       mem_read;
        logic       mem_write;
        logic       ir_load;
        logic       wb_sel_mem;
        logic [1:0] pc_next_sel;
        logic [1:0] alu_mode;
        logic [1:0] alu_b_sel;
        logic       alu_a_sel;
        logic       rf_write;
        logic       rf_dst_sel;
    } ctrl_t;

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  ustate_t addr,
    output ctrl_t   ctrl,
    output seq_t    seq
);
    always_comb begin
        ctrl = '0;
        seq  = SEQ_FETCH;
        unique case (addr)
            ST_FETCH: begin
                ctrl.mem_read  = 1'b1;
                ctrl.ir_load   = 1'b1;
                ctrl.pc_load   = 1'b1;
                ctrl.alu_b_sel = 2'b01;
                seq            = SEQ_NEXT;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = 2'b11;
                seq            = SEQ_DISP1;
            end
            ST_MEM_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = 2'b10;
                seq            = SEQ_DISP2;
            end
            ST_MEM_READ: begin
                ctrl.mem_read      = 1'b1;
                ctrl.addr_sel_data = 1'b1;
                seq                = SEQ_NEXT;
            end
            ST_LOAD_WB: begin
                ctrl.rf_write   = 1'b1;
                ctrl.wb_sel_mem = 1'b1;
                seq             = SEQ_FETCH;
            end
            ST_MEM_WRITE: begin
                ctrl.mem_write     = 1'b1;
                ctrl.addr_sel_data = 1'b1;
                seq                = SEQ_FETCH;
            end
            ST_EXECUTE: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_mode  = 2'b10;
                seq            = SEQ_NEXT;
            end
            ST_ALU_WB: begin
                ctrl.rf_write   = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
                seq             = SEQ_FETCH;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel       = 1'b1;
                ctrl.alu_mode        = 2'b01;
                ctrl.pc_load_if_zero = 1'b1;
                ctrl.pc_next_sel     = 2'b01;
                seq                  = SEQ_FETCH;
            end
            ST_JUMP: begin
                ctrl.pc_load     = 1'b1;
                ctrl.pc_next_sel = 2'b10;
                seq              = SEQ_FETCH;
            end
            default: begin
                ctrl = '0;
                seq  = SEQ_FETCH;
            end
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLE_ID = 1
) (
    input  logic [OPC_W-1:0] opcode,
    output ustate_t          target
);
    generate
        if (TABLE_ID == 1) begin : g_first
            always_comb begin
                unique case (opcode)
                    OP_RTYPE:          target = ST_EXECUTE;
                    OP_LOAD, OP_STORE: target = ST_MEM_ADDR;
                    OP_BEQ:            target = ST_BRANCH;
                    OP_JUMP:           target = ST_JUMP;
                    default:           target = ST_FETCH;
                endcase
            end
        end else begin : g_second
            always_comb begin
                unique case (opcode)
                    OP_LOAD:  target = ST_MEM_READ;
                    OP_STORE: target = ST_MEM_WRITE;
                    default:  target = ST_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/useq_addr_sel.sv
module useq_addr_sel
    import useq_pkg::*;
(
    input  seq_t    seq,
    input  ustate_t cur,
    input  ustate_t disp1,
    input  ustate_t disp2,
    output ustate_t nxt
);
    always_comb begin
        unique case (seq)
            SEQ_FETCH: nxt = ST_FETCH;
            SEQ_DISP1: nxt = disp1;
            SEQ_DISP2: nxt = disp2;
            SEQ_NEXT:  nxt = ustate_t'(UADDR_W'(cur + 1'b1));
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode,
    output logic                 pc_load,
    output logic                 pc_load_if_zero,
    output logic                 addr_sel_data,
    output logic                 mem_read,
    output logic                 mem_write,
    output logic                 ir_load,
    output logic                 wb_sel_mem,
    output logic [1:0]           pc_next_sel,
    output logic [1:0]           alu_mode,
    output logic [1:0]           alu_b_sel,
    output logic                 alu_a_sel,
    output logic                 rf_write,
    output logic                 rf_dst_sel,
    output logic [UADDR_W-1:0]   uaddr
);
    ustate_t upc, upc_nxt, disp1_tgt, disp2_tgt;
    ctrl_t   ctrl;
    seq_t    seq;

    useq_store u_store (.addr(upc), .ctrl(ctrl), .seq(seq));

    useq_dispatch #(.TABLE_ID(1)) u_disp1 (.opcode(opcode), .target(disp1_tgt));
    useq_dispatch #(.TABLE_ID(2)) u_disp2 (.opcode(opcode), .target(disp2_tgt));

    useq_addr_sel u_sel (
        .seq(seq), .cur(upc), .disp1(disp1_tgt), .disp2(disp2_tgt), .nxt(upc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) upc <= ST_FETCH;
        else     upc <= upc_nxt;
    end

    always_comb begin
        pc_load         = ctrl.pc_load;
        pc_load_if_zero = ctrl.pc_load_if_zero;
        addr_sel_data   = ctrl.addr_sel_data;
        mem_read        = ctrl.mem_read;
        mem_write       = ctrl.mem_write;
        ir_load         = ctrl.ir_load;
        wb_sel_mem      = ctrl.wb_sel_mem;
        pc_next_sel     = ctrl.pc_next_sel;
        alu_mode        = ctrl.alu_mode;
        alu_b_sel       = ctrl.alu_b_sel;
        alu_a_sel       = ctrl.alu_a_sel;
        rf_write        = ctrl.rf_write;
        rf_dst_sel      = ctrl.rf_dst_sel;
        uaddr           = upc;
    end
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk
    import useq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [OPC_W-1:0]   opcode,
    input logic               mem_read,
    input logic               mem_write,
    input logic [UADDR_W-1:0] uaddr
);
    logic op_in_first;
    assign op_in_first = (opcode == OP_RTYPE) || (opcode == OP_LOAD) ||
                         (opcode == OP_STORE) || (opcode == OP_BEQ) ||
                         (opcode == OP_JUMP);

    AST_FETCH_STEPS: assert property (@(posedge clk) disable iff (rst)
        uaddr == 4'd0 |=> uaddr == 4'd1); // R2
    AST_RETURN_HOME: assert property (@(posedge clk) disable iff (rst)
        (uaddr == 4'd4 || uaddr == 4'd5 || uaddr == 4'd7 || uaddr == 4'd8 || uaddr == 4'd9)
        |=> uaddr == 4'd0); // R3
    AST_DECODE_TARGET: assert property (@(posedge clk) disable iff (rst)
        uaddr == 4'd1 |=> (uaddr == 4'd0 || uaddr == 4'd2 || uaddr == 4'd6 ||
                           uaddr == 4'd8 || uaddr == 4'd9)); // R4
    AST_MEMADDR_TARGET: assert property (@(posedge clk) disable iff (rst)
        uaddr == 4'd2 |=> (uaddr == 4'd0 || uaddr == 4'd3 || uaddr == 4'd5)); // R5
    AST_UNLISTED_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (uaddr == 4'd1 && !op_in_first) |=> uaddr == 4'd0); // R6
    AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write)); // R7
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_read(mem_read), .mem_write(mem_write), .uaddr(uaddr)
);

// File: tb/useq_sequencer_test.sv
`timescale 1ns/1ps
module useq_sequencer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic pc_load, pc_load_if_zero, addr_sel_data, mem_read, mem_write, ir_load;
    logic wb_sel_mem, alu_a_sel, rf_write, rf_dst_sel;
    logic [1:0] pc_next_sel, alu_mode, alu_b_sel;
    logic [3:0] uaddr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    useq_sequencer uut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .addr_sel_data(addr_sel_data), .mem_read(mem_read), .mem_write(mem_write),
        .ir_load(ir_load), .wb_sel_mem(wb_sel_mem), .pc_next_sel(pc_next_sel),
        .alu_mode(alu_mode), .alu_b_sel(alu_b_sel), .alu_a_sel(alu_a_sel),
        .rf_write(rf_write), .rf_dst_sel(rf_dst_sel), .uaddr(uaddr)
    );

    // packing: pc_load, pc_load_if_zero, addr_sel_data, mem_read, mem_write,
    // ir_load, wb_sel_mem, pc_next_sel[2], alu_mode[2], alu_b_sel[2], alu_a_sel,
    // rf_write, rf_dst_sel
    function automatic logic [15:0] exp_ctrl(input logic [3:0] a);
        case (a)
            4'd0: return 16'b1_0_0_1_0_1_0_00_00_01_0_0_0;
            4'd1: return 16'b0_0_0_0_0_0_0_00_00_11_0_0_0;
            4'd2: return 16'b0_0_0_0_0_0_0_00_00_10_1_0_0;
            4'd3: return 16'b0_0_1_1_0_0_0_00_00_00_0_0_0;
            4'd4: return 16'b0_0_0_0_0_0_1_00_00_00_0_1_0;
            4'd5: return 16'b0_0_1_0_1_0_0_00_00_00_0_0_0;
            4'd6: return 16'b0_0_0_0_0_0_0_00_10_00_1_0_0;
            4'd7: return 16'b0_0_0_0_0_0_0_00_00_00_0_1_1;
            4'd8: return 16'b0_1_0_0_0_0_0_01_01_00_1_0_0;
            4'd9: return 16'b1_0_0_0_0_0_0_10_00_00_0_0_0;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] a, input logic [5:0] op);
        case (a)
            4'd0, 4'd3, 4'd6: return a + 4'd1;
            4'd1: case (op)
                      6'h00: return 4'd6;
                      6'h23, 6'h2B: return 4'd2;
                      6'h04: return 4'd8;
                      6'h02: return 4'd9;
                      default: return 4'd0;
                  endcase
            4'd2: case (op)
                      6'h23: return 4'd3;
                      6'h2B: return 4'd5;
                      default: return 4'd0;
                  endcase
            default: return 4'd0;
        endcase
    endfunction

    function automatic string trans_tag(input logic [3:0] a, input logic [5:0] op);
        if (a == 4'd0 || a == 4'd3 || a == 4'd6) return "R2";
        if (a == 4'd1) return (exp_next(a, op) == 4'd0) ? "R6" : "R4";
        if (a == 4'd2) return (exp_next(a, op) == 4'd0) ? "R6" : "R5";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [3:0] exp_a);
        logic [15:0] got;
        got = {pc_load, pc_load_if_zero, addr_sel_data, mem_read, mem_write, ir_load,
               wb_sel_mem, pc_next_sel, alu_mode, alu_b_sel, alu_a_sel, rf_write, rf_dst_sel};
        n_cmp++;
        if (uaddr !== exp_a) begin
            n_bad++;
            $display("FAIL %s uaddr actual %0d expected %0d", tag, uaddr, exp_a);
        end
        n_cmp++;
        if (got !== exp_ctrl(exp_a)) begin
            n_bad++;
            $display("FAIL R7 control at %0d actual %b expected %b", exp_a, got, exp_ctrl(exp_a));
        end
    endtask

    initial begin
        logic [3:0] model;
        logic [5:0] op;
        string tag;
        int ndec = 0;
        int nmem = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        model = 4'd0;
        check("R1", model);
        rst = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 8)
                0: op = 6'h00;
                1: op = 6'h23;
                2: op = 6'h2B;
                3: op = 6'h04;
                4: op = 6'h02;
                5: op = 6'h23;
                default: op = 6'($urandom);
            endcase
            if (model == 4'd1) begin
                ndec++;
                if (ndec % 7 == 0) op = 6'h3F;      // R6 directed, first table
            end
            if (model == 4'd2) begin
                nmem++;
                if (nmem % 5 == 0) op = 6'h04;      // R6 directed, second table
            end
            if (i == 700 || i == 1900 || (i == 2500 && model != 4'd0)) begin
                rst = 1'b1;                          // R1 mid-run reset
                tag = "R1";
                model = 4'd0;
            end else begin
                rst = 1'b0;
                tag = trans_tag(model, op);
                model = exp_next(model, op);
            end
            opcode = op;
            @(negedge clk);
            check(tag, model);
        end
        rst = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule